// File: doc/BRIEF.md
# Round-Robin Native-Vector Column Dispatcher

This block sits between a block fetch engine and a row of compute columns. After a start command, it takes one fetched block as a stream of 256-bit lines under a ready/valid handshake. The stream begins with a fixed run of exponent lines and continues with the mantissa lines of the vectors to be distributed. The block writes every vector into one column's tile buffer and exposes the writes as plain write ports. A column's buffer has a mantissa region, four lines per vector, and an exponent region, one 32-bit word per vector.

The start command carries two values: the number of vectors to hand out and a batch length. A run of consecutive vectors, as long as the batch length, goes to one column before the next column in round-robin order takes over. Each column has its own vector write pointer. The pointer survives from one dispatch to the next, so successive fetches append to a column instead of overwriting it. A clear command zeroes all pointers. A column that is full halts the dispatch and raises a sticky overflow flag.

Top module: `nv_col_dispatcher`

## Requirements
- R1: After reset, no write strobe is asserted, `line_ready_o`, `busy_o`, `done_o` and `overflow_o` are low and all column pointers are zero.
- R2: A start is taken only when the block is idle, overflow is low and the clear input is low. `line_ready_o` stays low while idle. The first 16 lines taken after a start are exponent lines: they are stored and they produce no write strobe.
- R3: Mantissa line j (0 to 3) of a vector is written one cycle after it is taken. The write goes to the target column at mantissa address pointer*4+j and carries the line unchanged.
- R4: Vector k of a dispatch goes to column floor(k/B) mod 4, where B is the batch length and 0 counts as 1. Each mantissa write asserts exactly one column strobe, with bit c meaning column c.
- R5: Together with the first mantissa line of vector k, the same column receives an exponent write. Its address is that column's vector pointer and its data is bits [(k mod 8)*32 +: 32] of exponent line floor(k/8). The other three lines produce no exponent write.
- R6: A column's pointer advances by one for each vector written to it and keeps its value across dispatches. Each dispatch starts again at column 0.
- R7: `done_o` is high for exactly one cycle, two clock edges after the last line of the dispatch is taken.
- R8: A clear request while idle sets all pointers to zero and drops the overflow flag.
- R9: A vector whose target column pointer already equals the capacity (128) is not taken. The block then raises `overflow_o`, returns to idle with no write and no done, and refuses starts until a clear.
- R10: A start pulse that arrives during a dispatch has no effect on that dispatch.
- R11: A vector count of zero takes only the 16 exponent lines, then signals done without any write.
- R12: While `line_valid_i` is low, nothing is taken and nothing is written, and the dispatch resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a dispatch |
| nv_total_i | input | 8 | Number of vectors in this dispatch (0 to 128) |
| batch_len_i | input | 8 | Vectors per column before switching (0 means 1) |
| clr_ptrs_i | input | 1 | Zero all column pointers and the overflow flag while idle |
| line_valid_i | input | 1 | Block line available |
| line_data_i | input | 256 | Block line |
| line_ready_o | output | 1 | Block line taken when valid is also high |
| man_we_o | output | 4 | Mantissa write strobe, one bit per column |
| man_addr_o | output | 9 | Mantissa line address in the column buffer |
| man_data_o | output | 256 | Mantissa line data |
| exp_we_o | output | 4 | Exponent write strobe, one bit per column |
| exp_addr_o | output | 7 | Exponent word address (vector index) |
| exp_data_o | output | 32 | Exponent word of the vector |
| busy_o | output | 1 | Dispatch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| overflow_o | output | 1 | Sticky column-full error |

## Verification
A wrong column cursor or batch counter shows up on the strobe of the very next write, as a column bit that does not match. A stale or wrongly advanced pointer gives a wrong mantissa or exponent address in the first write of the following vector, and that error is carried over into later dispatches. A wrong vector index into the exponent store shows as a wrong exponent word one cycle after a vector's first line is taken. Faults in the line counters show up either as a changed number of writes or as a done pulse that arrives one cycle off.

// File: rtl/nvd_pkg.sv
package nvd_pkg;
  typedef enum logic [1:0] {
    NVD_IDLE = 2'd0,
    NVD_EXP  = 2'd1,
    NVD_MAN  = 2'd2
  } nvd_phase_e;
endpackage

// File: rtl/nvd_exp_store.sv
// Holds the exponent lines of the current block; synchronous read of one word.
module nvd_exp_store #(
  parameter int LINE_W    = 256,
  parameter int EXP_W     = 32,
  parameter int EXP_LINES = 16,
  localparam int LIDX_W   = $clog2(EXP_LINES),
  localparam int WSEL_W   = $clog2(LINE_W / EXP_W)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LIDX_W-1:0] wr_line,
  input  logic [LINE_W-1:0] wr_data,
  input  logic [LIDX_W-1:0] rd_line,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [EXP_W-1:0]  rd_data
);
  logic [LINE_W-1:0] mem [EXP_LINES];
  logic [LINE_W-1:0] line_q;
  logic [WSEL_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_line] <= wr_data;
    line_q <= mem[rd_line];
    word_q <= rd_word;
  end

  assign rd_data = line_q[word_q*EXP_W +: EXP_W];
endmodule

// File: rtl/nvd_col_sched.sv
// Column cursor, batch counter and persistent per-column vector pointers.
module nvd_col_sched #(
  parameter int NUM_COLS = 4,
  parameter int CNT_W    = 8,
  parameter int PTR_W    = 8,
  parameter int COL_CAP  = 128,
  localparam int COL_W   = $clog2(NUM_COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             restart,
  input  logic [CNT_W-1:0] batch_len,
  input  logic             advance,
  output logic [COL_W-1:0] col_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o
);
  logic [COL_W-1:0] col_q;
  logic [CNT_W-1:0] bcnt_q;
  logic [CNT_W-1:0] blen_q;
  logic [NUM_COLS-1:0][PTR_W-1:0] ptrs;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q  <= '0;
      bcnt_q <= '0;
      blen_q <= CNT_W'(1);
    end else if (restart) begin
      col_q  <= '0;
      bcnt_q <= '0;
      blen_q <= (batch_len == '0) ? CNT_W'(1) : batch_len;
    end else if (advance) begin
      if (bcnt_q == blen_q - 1'b1) begin
        bcnt_q <= '0;
        col_q  <= (col_q == COL_W'(NUM_COLS - 1)) ? '0 : col_q + 1'b1;
      end else begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_COLS; g++) begin : g_ptr
    logic [PTR_W-1:0] p_q;
    always_ff @(posedge clk) begin
      if (rst || clear) p_q <= '0;
      else if (advance && col_q == COL_W'(g)) p_q <= p_q + 1'b1;
    end
    assign ptrs[g] = p_q;
  end

  assign col_o  = col_q;
  assign ptr_o  = ptrs[col_q];
  assign full_o = (ptr_o == PTR_W'(COL_CAP));
endmodule

// File: rtl/nvd_line_router.sv
// Registered column write ports and the done pipeline.
module nvd_line_router #(
  parameter int NUM_COLS = 4,
  parameter int LINE_W   = 256,
  parameter int VEC_AW   = 7,
  parameter int SUB_W    = 2,
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int MAN_AW  = VEC_AW + SUB_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic                first_line,
  input  logic                fin,
  input  logic [COL_W-1:0]    col,
  input  logic [VEC_AW-1:0]   vec_ptr,
  input  logic [SUB_W-1:0]    sub,
  input  logic [LINE_W-1:0]   data,
  output logic [NUM_COLS-1:0] man_we_o,
  output logic [MAN_AW-1:0]   man_addr_o,
  output logic [LINE_W-1:0]   man_data_o,
  output logic [NUM_COLS-1:0] exp_we_o,
  output logic [VEC_AW-1:0]   exp_addr_o,
  output logic                done_o
);
  logic [NUM_COLS-1:0] sel;
  logic                fin_q;

  assign sel = NUM_COLS'(1) << col;

  always_ff @(posedge clk) begin
    if (rst) begin
      man_we_o <= '0;
      exp_we_o <= '0;
      fin_q    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      man_we_o <= fire ? sel : '0;
      exp_we_o <= (fire && first_line) ? sel : '0;
      fin_q    <= fin;
      done_o   <= fin_q;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      man_addr_o <= {vec_ptr, sub};
      man_data_o <= data;
      exp_addr_o <= vec_ptr;
    end
  end
endmodule

// File: rtl/nv_col_dispatcher.sv
module nv_col_dispatcher #(
  parameter int NUM_COLS         = 4,
  parameter int LINE_W           = 256,
  parameter int NV_PER_BLOCK     = 128,
  parameter int MAN_LINES_PER_NV = 4,
  parameter int EXP_BYTES_PER_NV = 4,
  parameter int COL_CAP          = 128,
  localparam int EXP_W           = EXP_BYTES_PER_NV * 8,
  localparam int EXP_PER_LINE    = LINE_W / EXP_W,
  localparam int EXP_LINES       = NV_PER_BLOCK / EXP_PER_LINE,
  localparam int CNT_W           = $clog2(NV_PER_BLOCK + 1),
  localparam int PTR_W           = $clog2(COL_CAP + 1),
  localparam int VEC_AW          = $clog2(COL_CAP),
  localparam int SUB_W           = $clog2(MAN_LINES_PER_NV),
  localparam int MAN_AW          = VEC_AW + SUB_W,
  localparam int LIDX_W          = $clog2(EXP_LINES),
  localparam int WSEL_W          = $clog2(EXP_PER_LINE),
  localparam int COL_W           = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    nv_total_i,
  input  logic [CNT_W-1:0]    batch_len_i,
  input  logic                clr_ptrs_i,
  input  logic                line_valid_i,
  input  logic [LINE_W-1:0]   line_data_i,
  output logic                line_ready_o,
  output logic [NUM_COLS-1:0] man_we_o,
  output logic [MAN_AW-1:0]   man_addr_o,
  output logic [LINE_W-1:0]   man_data_o,
  output logic [NUM_COLS-1:0] exp_we_o,
  output logic [VEC_AW-1:0]   exp_addr_o,
  output logic [EXP_W-1:0]    exp_data_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                overflow_o
);
  import nvd_pkg::*;

  nvd_phase_e        phase_q;
  logic [LIDX_W-1:0] eidx_q;
  logic [CNT_W-1:0]  vidx_q;
  logic [CNT_W-1:0]  total_q;
  logic [SUB_W-1:0]  sub_q;
  logic              ovf_q;

  logic [COL_W-1:0]  col;
  logic [PTR_W-1:0]  cptr;
  logic              cfull;

  logic clr_ok, take, blocked, ready, fire, efire, mfire;
  logic vdone, mlast, elast, fin;

  assign clr_ok  = clr_ptrs_i && (phase_q == NVD_IDLE);
  assign take    = (phase_q == NVD_IDLE) && start_i && !clr_ptrs_i && !ovf_q;
  assign blocked = (phase_q == NVD_MAN) && (sub_q == '0) && cfull;
  assign ready   = (phase_q == NVD_EXP) || ((phase_q == NVD_MAN) && !blocked);
  assign fire    = line_valid_i && ready;
  assign efire   = fire && (phase_q == NVD_EXP);
  assign mfire   = fire && (phase_q == NVD_MAN);
  assign vdone   = mfire && (sub_q == SUB_W'(MAN_LINES_PER_NV - 1));
  assign mlast   = vdone && (vidx_q == total_q - 1'b1);
  assign elast   = efire && (eidx_q == LIDX_W'(EXP_LINES - 1));
  assign fin     = mlast || (elast && (total_q == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= NVD_IDLE;
      eidx_q  <= '0;
      vidx_q  <= '0;
      total_q <= '0;
      sub_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      case (phase_q)
        NVD_IDLE: begin
          if (clr_ok) ovf_q <= 1'b0;
          if (take) begin
            phase_q <= NVD_EXP;
            total_q <= nv_total_i;
            eidx_q  <= '0;
            vidx_q  <= '0;
            sub_q   <= '0;
          end
        end
        NVD_EXP: begin
          if (efire) begin
            eidx_q <= eidx_q + 1'b1;
            if (elast) phase_q <= (total_q == '0) ? NVD_IDLE : NVD_MAN;
          end
        end
        NVD_MAN: begin
          if (blocked) begin
            ovf_q   <= 1'b1;
            phase_q <= NVD_IDLE;
          end else if (mfire) begin
            sub_q <= sub_q + 1'b1;
            if (vdone) vidx_q <= vidx_q + 1'b1;
            if (mlast) phase_q <= NVD_IDLE;
          end
        end
        default: phase_q <= NVD_IDLE;
      endcase
    end
  end

  nvd_exp_store #(
    .LINE_W(LINE_W), .EXP_W(EXP_W), .EXP_LINES(EXP_LINES)
  ) u_exp (
    .clk     (clk),
    .wr_en   (efire),
    .wr_line (eidx_q),
    .wr_data (line_data_i),
    .rd_line (LIDX_W'(vidx_q >> WSEL_W)),
    .rd_word (WSEL_W'(vidx_q)),
    .rd_data (exp_data_o)
  );

  nvd_col_sched #(
    .NUM_COLS(NUM_COLS), .CNT_W(CNT_W), .PTR_W(PTR_W), .COL_CAP(COL_CAP)
  ) u_sched (
    .clk       (clk),
    .rst       (rst),
    .clear     (clr_ok),
    .restart   (take),
    .batch_len (batch_len_i),
    .advance   (vdone),
    .col_o     (col),
    .ptr_o     (cptr),
    .full_o    (cfull)
  );

  nvd_line_router #(
    .NUM_COLS(NUM_COLS), .LINE_W(LINE_W), .VEC_AW(VEC_AW), .SUB_W(SUB_W)
  ) u_route (
    .clk        (clk),
    .rst        (rst),
    .fire       (mfire),
    .first_line (sub_q == '0),
    .fin        (fin),
    .col        (col),
    .vec_ptr    (VEC_AW'(cptr)),
    .sub        (sub_q),
    .data       (line_data_i),
    .man_we_o   (man_we_o),
    .man_addr_o (man_addr_o),
    .man_data_o (man_data_o),
    .exp_we_o   (exp_we_o),
    .exp_addr_o (exp_addr_o),
    .done_o     (done_o)
  );

  assign line_ready_o = ready;
  assign busy_o       = (phase_q != NVD_IDLE);
  assign overflow_o   = ovf_q;
endmodule

// File: rtl/nv_col_dispatcher_chk.sv
module nv_col_dispatcher_chk #(
  parameter int NUM_COLS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                clr_ptrs_i,
  input logic                line_ready_o,
  input logic [NUM_COLS-1:0] man_we_o,
  input logic [NUM_COLS-1:0] exp_we_o,
  input logic                busy_o,
  input logic                done_o,
  input logic                overflow_o
);
  a_r2_idle_no_ready: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !line_ready_o);

  a_r4_one_column: assert property (@(posedge clk) disable iff (rst)
    $onehot0(man_we_o));

  a_r5_exp_with_man: assert property (@(posedge clk) disable iff (rst)
    (exp_we_o != '0) |-> (exp_we_o == man_we_o));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r9_overflow_quiet: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> (man_we_o == '0 && !line_ready_o && !busy_o));

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow_o && !clr_ptrs_i) |=> overflow_o);
endmodule

bind nv_col_dispatcher nv_col_dispatcher_chk #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .clr_ptrs_i   (clr_ptrs_i),
  .line_ready_o (line_ready_o),
  .man_we_o     (man_we_o),
  .exp_we_o     (exp_we_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .overflow_o   (overflow_o)
);

// File: tb/nv_col_dispatcher_tb.sv
module nv_col_dispatcher_tb;
  localparam int NC = 4;
  localparam int EL = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [7:0]   nv_total_i = '0;
  logic [7:0]   batch_len_i = '0;
  logic         clr_ptrs_i = 1'b0;
  logic         line_valid_i = 1'b0;
  logic [255:0] line_data_i = '0;
  logic         line_ready_o;
  logic [3:0]   man_we_o;
  logic [8:0]   man_addr_o;
  logic [255:0] man_data_o;
  logic [3:0]   exp_we_o;
  logic [6:0]   exp_addr_o;
  logic [31:0]  exp_data_o;
  logic         busy_o, done_o, overflow_o;

  always #4 clk = ~clk;

  nv_col_dispatcher u_dut (.*);

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mline(input logic [7:0] id, input int idx);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) begin
      if (idx < EL) r[w*32 +: 32] = {id, 8'hEE, 8'(idx), 8'(w)};
      else          r[w*32 +: 32] = {id, 8'hAA, 16'(idx)};
    end
    return r;
  endfunction

  // stimulus table: {count, batch, valid gaps, start poke mid-stream}
  localparam logic [17:0] TBL [4] = '{
    {8'd16, 8'd1, 1'b0, 1'b0},
    {8'd32, 8'd8, 1'b1, 1'b0},
    {8'd13, 8'd3, 1'b0, 1'b1},
    {8'd10, 8'd0, 1'b1, 1'b1}
  };

  // write monitor model
  logic [7:0] m_id = '0;
  int         m_batch = 1;
  int         m_k = 0;
  int         m_done = 0;
  int         mptr [NC] = '{0, 0, 0, 0};
  int         first_addr = 0;
  bit         first_seen = 1'b0;

  always @(negedge clk) begin
    int v, s, c;
    if (!rst) begin
      if (done_o) m_done++;
      if (man_we_o != '0 || exp_we_o != '0) begin
        v = m_k / 4;
        s = m_k % 4;
        c = (v / m_batch) % NC;
        if (!first_seen) begin first_addr = int'(man_addr_o); first_seen = 1'b1; end
        chk(man_we_o == 4'(1 << c), "R4", "mantissa column", man_we_o, 4'(1 << c));
        chk(man_addr_o == 9'(mptr[c]*4 + s), "R3/R6", "mantissa address",
            man_addr_o, 9'(mptr[c]*4 + s));
        chk(man_data_o == mline(m_id, EL + m_k), "R3", "mantissa data",
            man_data_o, mline(m_id, EL + m_k));
        if (s == 0) begin
          chk(exp_we_o == 4'(1 << c), "R5", "exponent column", exp_we_o, 4'(1 << c));
          chk(exp_addr_o == 7'(mptr[c]), "R5/R6", "exponent address", exp_addr_o, 7'(mptr[c]));
          chk(exp_data_o == {m_id, 8'hEE, 8'(v / 8), 8'(v % 8)}, "R5", "exponent data",
              exp_data_o, {m_id, 8'hEE, 8'(v / 8), 8'(v % 8)});
        end else begin
          chk(exp_we_o == '0, "R5", "exponent strobe on later line", exp_we_o, 0);
        end
        if (s == 3) mptr[c]++;
        m_k++;
      end
    end
  end

  task automatic drive_lines(input logic [7:0] id, input int from, input int to,
                             input bit gap, input int poke_at);
    int  i = from;
    int  g = 0;
    bit  acc;
    while (i < to) begin
      @(negedge clk);
      start_i = 1'b0;
      if (gap && (g % 3 == 1)) begin
        line_valid_i = 1'b0;  // R12 stall
      end else begin
        line_valid_i = 1'b1;
        line_data_i  = mline(id, i);
      end
      if (i == poke_at) begin  // R10 start during a dispatch
        start_i = 1'b1; nv_total_i = 8'd3; batch_len_i = 8'd1;
      end
      g++;
      #1;
      acc = line_valid_i && line_ready_o;
      @(posedge clk);
      if (acc) i++;
    end
  endtask

  task automatic arm(input logic [7:0] id, input int nv, input int b);
    m_id = id; m_batch = (b == 0) ? 1 : b; m_k = 0; m_done = 0; first_seen = 1'b0;
    @(negedge clk);
    start_i = 1'b1; nv_total_i = 8'(nv); batch_len_i = 8'(b);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_dispatch(input logic [7:0] id, input int nv, input int b,
                              input bit gap, input bit poke);
    arm(id, nv, b);
    chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    drive_lines(id, 0, EL + 4*nv, gap, poke ? EL + 4 : -1);
    @(negedge clk);
    line_valid_i = 1'b0; start_i = 1'b0;
    chk(done_o == 1'b0, "R7", "done one edge after last line", done_o, 0);
    @(negedge clk);
    chk(done_o == 1'b1, "R7", "done two edges after last line", done_o, 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R7", "done width", done_o, 0);
    chk(m_k == 4*nv, "R3/R12", "mantissa write count", m_k, 4*nv);
    chk(busy_o == 1'b0 && m_done == 1, "R10", "single completion", m_done, 1);
  endtask

  task automatic clear_ptrs();
    @(negedge clk); clr_ptrs_i = 1'b1;
    @(negedge clk); clr_ptrs_i = 1'b0;
    for (int c = 0; c < NC; c++) mptr[c] = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(man_we_o == '0 && exp_we_o == '0, "R1", "strobes after reset", {man_we_o, exp_we_o}, 0);
    chk(!line_ready_o && !busy_o, "R1", "ready/busy after reset", {line_ready_o, busy_o}, 0);
    chk(!done_o && !overflow_o, "R1", "done/overflow after reset", {done_o, overflow_o}, 0);
    line_valid_i = 1'b1; line_data_i = mline(8'hFF, 0);
    repeat (2) @(negedge clk);
    chk(!line_ready_o && m_k == 0, "R2", "idle refuses lines", line_ready_o, 0);
    line_valid_i = 1'b0;

    for (int t = 0; t < 4; t++) begin
      run_dispatch(8'(t + 1), int'(TBL[t][17:10]), int'(TBL[t][9:2]), TBL[t][1], TBL[t][0]);
      if (t == 0) chk(first_addr == 0, "R1", "pointers start at zero", first_addr, 0);
      if (t == 1) chk(first_addr == 16, "R6", "second dispatch appends", first_addr, 16);
    end

    clear_ptrs();
    run_dispatch(8'd5, 4, 1, 1'b0, 1'b0);
    chk(first_addr == 0, "R8", "clear restarts addresses", first_addr, 0);

    run_dispatch(8'd6, 0, 1, 1'b0, 1'b0);
    chk(m_k == 0, "R11", "zero count writes nothing", m_k, 0);

    clear_ptrs();
    run_dispatch(8'd7, 128, 128, 1'b0, 1'b0);
    chk(mptr[0] == 128, "R4", "whole block to column 0", mptr[0], 128);

    arm(8'd8, 2, 1);
    drive_lines(8'd8, 0, EL, 1'b0, -1);
    @(negedge clk);
    line_valid_i = 1'b1; line_data_i = mline(8'd8, EL);
    repeat (4) @(negedge clk);
    chk(overflow_o == 1'b1, "R9", "overflow flag", overflow_o, 1);
    chk(line_ready_o == 1'b0, "R9", "line refused", line_ready_o, 0);
    chk(busy_o == 1'b0, "R9", "dispatch abandoned", busy_o, 0);
    chk(m_k == 0 && m_done == 0, "R9", "no write, no done", {m_k[7:0], m_done[7:0]}, 0);
    line_valid_i = 1'b0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b0, "R9", "start refused while overflowed", busy_o, 0);
    clear_ptrs();
    chk(overflow_o == 1'b0, "R8", "clear drops overflow", overflow_o, 0);
    run_dispatch(8'd9, 2, 1, 1'b0, 1'b0);
    chk(first_addr == 0, "R8", "column 0 reusable after clear", first_addr, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule